// File: doc/BRIEF.md
# Always-On Auxiliary Interrupt Controller

This block is a small interrupt controller that sits in an always-on power domain and serves two consumers at once. The main processor's interrupt controller receives a gated copy of the non-maskable pin and a raw, unlatched copy of fifteen direct interrupt lines. The power-management coprocessor receives a single combined request, built from the locally latched pending state of every input, qualified by per-input enable and mask bits.

Input 0 is the non-maskable pin. Its trigger (low level, falling edge, high level or rising edge) is programmable. Inputs 1 to 15 are direct lines. Inputs 16 to 19 are banked peripheral lines. All remaining inputs are multiplexer slots: each slot latches one line, chosen by software from a wider set of 128 shared interrupt lines. All external signals pass through a two-flop synchroniser before they are latched. Software uses a word-addressed register bus with a single-cycle write strobe and a combinational read path.

Top module: `aoic_top`

## Requirements
- R1: After reset, the pending, enable, mask and slot-select registers read zero. The trigger field reads 2'b11 (rising edge). `main_nmi_irq` and `cop_irq` are low.
- R2: The trigger field sits in bits [1:0] of word address 0. 00 sets pending bit 0 while the synchronised pin is low, 01 on a falling edge, 10 while it is high, and 11 on a rising edge. Pending bit 0 changes on the third rising clock edge after the pin changes.
- R3: `main_nmi_irq` is high exactly when pending bit 0 and enable bit 0 are both set. Clearing enable bit 0 drops `main_nmi_irq` after the write edge, while pending bit 0 stays set.
- R4: `main_direct_irq` follows `direct_irq` combinationally, whatever the enables hold. Direct line i is also latched into pending bit i+1.
- R5: Banked line j is latched into pending bit 16+j.
- R6: Multiplexer slot k drives input 20+k. It latches the shared line whose 7-bit index is held in the field at bits [8*(k%4)+6 : 8*(k%4)] of word address 16+k/4. That field reads back unchanged. Unselected shared lines have no effect on the slot.
- R7: Rewriting a slot's select field does not clear that slot's pending bit.
- R8: Pending is write-1-to-clear at word address 4 (bits 31:0); bit positions written with 0 are unchanged. When a write clears a bit, the clear takes priority in that cycle. A level source that is still asserted sets the bit again on the next edge.
- R9: `cop_irq` is the OR over all inputs of pending AND enable AND NOT mask. The enable word is at address 8 and the mask word at address 12.
- R10: A pending bit never falls except through a write to the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin (asynchronous) |
| direct_irq | input | 15 | Direct interrupt lines, inputs 1..15 |
| bank_irq | input | 4 | Banked peripheral lines, inputs 16..19 |
| shared_irq | input | 128 | Shared interrupt lines feeding the slot multiplexers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| main_nmi_irq | output | 1 | Gated non-maskable request to the main controller |
| main_direct_irq | output | 15 | Pass-through of the direct lines to the main controller |
| cop_irq | output | 1 | Combined request to the coprocessor |

## Verification
The bench walks all four trigger encodings, using pin transitions that should fire and ones that should not. A swapped encoding, or an edge detector that compares the wrong samples, would latch on the wrong transition or miss the right one. It clears a pending bit while its level source is still held high and checks the bit is zero right after the write and set again one edge later. A design that lets the set win, or that loses the re-set, fails here. It also rewrites a slot select after the slot has latched, to catch logic that clears pending on a select change. Finally, it disables bit 0 while the pin's pending bit is held, to catch a main-side line that ignores the enable or that clears pending as a side effect.

// File: rtl/aoic_pkg.sv
package aoic_pkg;

    // Trigger selection for the non-maskable pin
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_HIGH = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 32;

    // Word addresses of the register groups
    localparam int A_CTRL       = 0;
    localparam int A_PEND       = 4;
    localparam int A_EN         = 8;
    localparam int A_MASK       = 12;
    localparam int A_SEL        = 16;

    // Slot-select packing: four byte-wide fields per word
    localparam int SEL_FIELD_W  = 8;
    localparam int SEL_PER_WORD = DATA_W / SEL_FIELD_W;

endpackage

// File: rtl/aoic_sync.sv
module aoic_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] sync_d, sync_q;

    always_comb begin
        meta_d = async_i;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/aoic_nmi_detect.sv
module aoic_nmi_detect
    import aoic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level_i,
    input  trig_e mode_i,
    output logic  hit_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
        unique case (mode_i)
            TRIG_LOW:  hit_o = ~level_i;
            TRIG_FALL: hit_o = ~level_i & prev_q;
            TRIG_HIGH: hit_o = level_i;
            TRIG_RISE: hit_o = level_i & ~prev_q;
            default:   hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/aoic_src_mux.sv
module aoic_src_mux #(
    parameter int NUM_SLOTS  = 12,
    parameter int NUM_SHARED = 128,
    parameter int SEL_W      = $clog2(NUM_SHARED)
) (
    input  logic [NUM_SHARED-1:0]           lines_i,
    input  logic [NUM_SLOTS-1:0][SEL_W-1:0] sel_i,
    output logic [NUM_SLOTS-1:0]            slot_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            if (int'(sel_i[g]) < NUM_SHARED) slot_o[g] = lines_i[sel_i[g]];
            else                             slot_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/aoic_top.sv
module aoic_top
    import aoic_pkg::*;
#(
    parameter int NUM_IN     = 32,
    parameter int NUM_DIRECT = 15,
    parameter int NUM_BANK   = 4,
    parameter int NUM_SHARED = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nmi_pin,
    input  logic [NUM_DIRECT-1:0] direct_irq,
    input  logic [NUM_BANK-1:0]   bank_irq,
    input  logic [NUM_SHARED-1:0] shared_irq,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  main_nmi_irq,
    output logic [NUM_DIRECT-1:0] main_direct_irq,
    output logic                  cop_irq
);

    localparam int NUM_WORDS = NUM_IN / DATA_W;
    localparam int MUX_BASE  = 1 + NUM_DIRECT + NUM_BANK;
    localparam int NUM_SLOTS = NUM_IN - MUX_BASE;
    localparam int SEL_W     = $clog2(NUM_SHARED);

    typedef struct packed {
        trig_e                          trig;
        logic [NUM_IN-1:0]              pend;
        logic [NUM_IN-1:0]              en;
        logic [NUM_IN-1:0]              mask;
        logic [NUM_SLOTS-1:0][SEL_W-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] slot_raw;
    logic [NUM_IN-1:0]    raw_in;
    logic [NUM_IN-1:0]    sync_in;
    logic                 nmi_hit;
    logic [NUM_IN-1:0]    src;
    logic [NUM_IN-1:0]    clr;
    logic [NUM_IN-1:0]    pend_vec;
    logic [NUM_IN-1:0]    en_vec;

    aoic_src_mux #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SHARED(NUM_SHARED),
        .SEL_W     (SEL_W)
    ) u_mux (
        .lines_i(shared_irq),
        .sel_i  (st_q.sel),
        .slot_o (slot_raw)
    );

    assign raw_in = {slot_raw, bank_irq, direct_irq, nmi_pin};

    aoic_sync #(.W(NUM_IN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    aoic_nmi_detect u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(sync_in[0]),
        .mode_i (st_q.trig),
        .hit_o  (nmi_hit)
    );

    assign src = {sync_in[NUM_IN-1:1], nmi_hit};

    // Next-state computation
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_we) begin
            if (int'(bus_addr) == A_CTRL) st_d.trig = trig_e'(bus_wdata[1:0]);
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (int'(bus_addr) == A_PEND + w) clr[w*DATA_W +: DATA_W]       = bus_wdata;
                if (int'(bus_addr) == A_EN + w)   st_d.en[w*DATA_W +: DATA_W]   = bus_wdata;
                if (int'(bus_addr) == A_MASK + w) st_d.mask[w*DATA_W +: DATA_W] = bus_wdata;
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (int'(bus_addr) == A_SEL + s / SEL_PER_WORD)
                    st_d.sel[s] = bus_wdata[(s % SEL_PER_WORD) * SEL_FIELD_W +: SEL_W];
            end
        end
        // a clear written this cycle takes priority over a new set
        st_d.pend = (st_q.pend | src) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trig <= TRIG_RISE;
            st_q.pend <= '0;
            st_q.en   <= '0;
            st_q.mask <= '0;
            st_q.sel  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == A_CTRL) bus_rdata[1:0] = st_q.trig;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(bus_addr) == A_PEND + w) bus_rdata = st_q.pend[w*DATA_W +: DATA_W];
            if (int'(bus_addr) == A_EN + w)   bus_rdata = st_q.en[w*DATA_W +: DATA_W];
            if (int'(bus_addr) == A_MASK + w) bus_rdata = st_q.mask[w*DATA_W +: DATA_W];
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (int'(bus_addr) == A_SEL + s / SEL_PER_WORD)
                bus_rdata[(s % SEL_PER_WORD) * SEL_FIELD_W +: SEL_W] = st_q.sel[s];
        end
    end

    assign main_nmi_irq    = st_q.pend[0] & st_q.en[0];
    assign main_direct_irq = direct_irq;
    assign cop_irq         = |(st_q.pend & st_q.en & ~st_q.mask);

    assign pend_vec = st_q.pend;
    assign en_vec   = st_q.en;

endmodule

// File: rtl/aoic_chk.sv
module aoic_chk
    import aoic_pkg::*;
#(
    parameter int NUM_IN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_IN-1:0] pend,
    input logic [NUM_IN-1:0] en,
    input logic              main_nmi_irq,
    input logic              cop_irq
);

    // R3
    nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == A_EN && !bus_wdata[0]) |=> !main_nmi_irq);

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == A_PEND) |=> ((pend[DATA_W-1:0] & $past(bus_wdata)) == '0));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (int'(bus_addr) == A_PEND || int'(bus_addr) == A_PEND + 1))
        |=> ((pend & $past(pend)) == $past(pend)));

    // R9
    cop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !cop_irq);

endmodule

bind aoic_top aoic_chk #(.NUM_IN(NUM_IN)) u_aoic_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pend        (pend_vec),
    .en          (en_vec),
    .main_nmi_irq(main_nmi_irq),
    .cop_irq     (cop_irq)
);

// File: tb/test_aoic_top.sv
`timescale 1ns/1ps
module test_aoic_top;

    localparam int A_CTRL = 0, A_PEND = 4, A_EN = 8, A_MASK = 12, A_SEL = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nmi_pin = 1'b0;
    logic [14:0]  direct_irq = '0;
    logic [3:0]   bank_irq = '0;
    logic [127:0] shared_irq = '0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         main_nmi_irq;
    logic [14:0]  main_direct_irq;
    logic         cop_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    aoic_top i_aoic_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .nmi_pin        (nmi_pin),
        .direct_irq     (direct_irq),
        .bank_irq       (bank_irq),
        .shared_irq     (shared_irq),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .main_nmi_irq   (main_nmi_irq),
        .main_direct_irq(main_direct_irq),
        .cop_irq        (cop_irq)
    );

    // trigger table: {mode[1:0], pin before, pin after, expected pending bit 0}
    localparam logic [4:0] NMI_VEC [8] = '{
        {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0},
        {2'b10, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b0, 1'b0, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 5'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_PEND, d); chk("R1 pend", d, 32'h0);
        rd(A_EN, d);   chk("R1 en", d, 32'h0);
        rd(A_MASK, d); chk("R1 mask", d, 32'h0);
        rd(A_SEL, d);  chk("R1 sel", d, 32'h0);
        rd(A_CTRL, d); chk("R1 trig", d, 32'h3);
        chk("R1 outs", {30'h0, main_nmi_irq, cop_irq}, 32'h0);

        // R2 trigger table
        for (int i = 0; i < 8; i++) begin
            nmi_pin = NMI_VEC[i][2];
            wr(A_CTRL, {30'h0, NMI_VEC[i][4:3]});
            idle(5);
            wr(A_PEND, 32'h1);
            nmi_pin = NMI_VEC[i][1];
            idle(5);
            rd(A_PEND, d);
            chk($sformatf("R2 vec%0d", i), d & 32'h1, {31'h0, NMI_VEC[i][0]});
        end

        // R2 latency and R3 gating
        nmi_pin = 1'b0;
        wr(A_CTRL, 32'h3);
        idle(5);
        wr(A_PEND, 32'hFFFF_FFFF);
        nmi_pin = 1'b1;
        idle(2);
        rd(A_PEND, d); chk("R2 before third edge", d & 32'h1, 32'h0);
        idle(1);
        rd(A_PEND, d); chk("R2 at third edge", d & 32'h1, 32'h1);
        chk("R3 disabled", {31'h0, main_nmi_irq}, 32'h0);
        wr(A_EN, 32'h1);
        chk("R3 enabled", {31'h0, main_nmi_irq}, 32'h1);
        wr(A_EN, 32'h0);
        chk("R3 re-disabled", {31'h0, main_nmi_irq}, 32'h0);
        rd(A_PEND, d); chk("R3 pend held", d & 32'h1, 32'h1);
        wr(A_PEND, 32'h1);
        rd(A_PEND, d); chk("R8 nmi cleared", d, 32'h0);

        // R4 direct lines
        direct_irq = 15'h2A5B;
        #1 chk("R4 pass-through", {17'h0, main_direct_irq}, {17'h0, 15'h2A5B});
        idle(4);
        rd(A_PEND, d); chk("R4 latched", d, 32'h0000_54B6);
        chk("R9 no enable", {31'h0, cop_irq}, 32'h0);

        // R8 write-1-to-clear with level still asserted
        wr(A_PEND, 32'h0);
        rd(A_PEND, d); chk("R8 zero write", d, 32'h0000_54B6);
        wr(A_PEND, 32'h2);
        rd(A_PEND, d); chk("R8 clear wins", d, 32'h0000_54B4);
        idle(1);
        rd(A_PEND, d); chk("R8 level re-set", d, 32'h0000_54B6);
        direct_irq = '0;
        idle(4);
        wr(A_PEND, 32'hFFFF_FFFF);
        rd(A_PEND, d); chk("R8 all cleared", d, 32'h0);

        // R5 banked lines
        bank_irq = 4'b0010;
        idle(4);
        rd(A_PEND, d); chk("R5 banked", d, 32'h0002_0000);
        bank_irq = '0;
        idle(4);
        wr(A_PEND, 32'hFFFF_FFFF);

        // R6 multiplexer slots 0 and 5 on line 77
        wr(A_SEL, 32'd77);
        wr(A_SEL + 1, 32'h0000_4D00);
        rd(A_SEL, d);     chk("R6 sel0 readback", d, 32'h0000_004D);
        rd(A_SEL + 1, d); chk("R6 sel5 readback", d, 32'h0000_4D00);
        shared_irq[5] = 1'b1;
        idle(4);
        rd(A_PEND, d); chk("R6 unselected line", d, 32'h0);
        shared_irq[77] = 1'b1;
        idle(4);
        rd(A_PEND, d); chk("R6 selected line", d, 32'h0210_0000);

        // R7 reselect keeps pending
        shared_irq = '0;
        wr(A_SEL, 32'd3);
        idle(4);
        rd(A_PEND, d); chk("R7 reselect", d, 32'h0210_0000);

        // R9 coprocessor request
        wr(A_EN, 32'h0010_0000);
        chk("R9 enabled", {31'h0, cop_irq}, 32'h1);
        wr(A_MASK, 32'h0010_0000);
        chk("R9 masked", {31'h0, cop_irq}, 32'h0);
        wr(A_MASK, 32'h0);
        chk("R9 unmasked", {31'h0, cop_irq}, 32'h1);
        wr(A_EN, 32'h0);
        chk("R9 disabled", {31'h0, cop_irq}, 32'h0);
        rd(A_PEND, d); chk("R10 held through writes", d, 32'h0210_0000);
        wr(A_PEND, 32'h0010_0000);
        rd(A_PEND, d); chk("R8 partial clear", d, 32'h0200_0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule